// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side and decides whether an embedded program or erase operation inside a NOR flash device has finished. A one-cycle `start` pulse latches the status address and begins polling. The poller issues status reads over a simple request/acknowledge read port and compares the selected toggle bit across two consecutive reads. It watches the timeout flag on data bit 5 and finishes with a one-cycle `done` pulse, plus `fail` when the operation did not complete.

When the toggle bit keeps changing and the timeout flag is low, the poller takes a new pair of reads. When the flag is high, it takes two more reads to re-check the toggle bit, because toggling can stop at the same moment the flag rises. On failure, either a confirmed timeout or an exhausted poll budget, it writes the reset command so the device returns to array reads. An `abort` input drops polling at once and discards the stored toggle value. A later `start` then begins again from a fresh first read.

States and transitions: `ST_IDLE` goes to `ST_RD_A` on `start`. `ST_RD_A` goes to `ST_RD_B` on acknowledge and stores the toggle bit. `ST_RD_B` acts on acknowledge in one of four ways:
- It goes to `ST_FINISH` when the bit is stable.
- It goes to `ST_CHK_A` when the bit toggled and the flag is set.
- It goes to `ST_RESET_WR` when the bit toggled, the flag is clear and the budget is used up.
- It goes back to `ST_RD_A` otherwise.

`ST_CHK_A` goes to `ST_CHK_B` on acknowledge and stores the bit. `ST_CHK_B` goes to `ST_FINISH` when the bit is stable and to `ST_RESET_WR` when it still toggles. `ST_RESET_WR` goes to `ST_FINISH` when the write is acknowledged. `ST_FINISH` always returns to `ST_IDLE`. `abort` forces any state to `ST_IDLE`.

Top module: `flash_toggle_poller`

## Requirements
- R1: When `start` is seen in idle, the block raises `bus_req` with `bus_we`=0 at the address given on `status_addr`. Each request holds its address and direction until `bus_ack`.
- R2: The selected toggle bit of the first read is stored. If the second read returns the same value, `done` rises with `fail`=0 in the cycle after that read's acknowledge, and no write is issued.
- R3: If the toggle bit differs and bit 5 of the second read is 0, a new read pair starts, and polling continues until the bit is stable.
- R4: If the toggle bit differs and bit 5 of the second read is 1, two more reads are taken. If the bit is equal across those two reads, the result is success.
- R5: If the bit still differs on the re-check pair, the block issues one write (`bus_we`=1) of data 0x00F0 to the status address. `done` and `fail` then rise together in the cycle after that write's acknowledge.
- R6: `done` is high for exactly one cycle per run, and `fail` is never high without `done`.
- R7: When `poll_limit` is N>0, the block allows at most N read pairs that toggle with bit 5 low. On the Nth such pair it writes the reset command and ends with `fail`=1. When `poll_limit` is 0, polling is unbounded.
- R8: `abort` returns the block to idle in the next cycle: `busy` and `bus_req` go low and no `done` follows. A later `start` begins with a new first read and does not reuse the stored bit.
- R9: The toggle bit is data bit 6 by default, or bit 2 when `SECTOR_BIT` is 1. Changes on other bits, apart from the flag on bit 5, do not affect the result.
- R10: A `start` pulse while `busy` is high is ignored: the run in progress keeps its read count and produces a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll run (honoured only when idle) |
| abort | input | 1 | Abandon polling and return to idle |
| status_addr | input | AW | Address used for status reads and the reset write |
| poll_limit | input | CW | Maximum toggling read pairs with flag low; 0 means no limit |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 for the reset-command write, 0 for reads |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data (reset command during writes) |
| bus_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| bus_rdata | input | DW | Read data from the device |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Qualifies `done`: operation did not complete |

## Verification
The hardest path to reach is the one where the toggle bit stops in the same window in which the timeout flag rises, so that success is declared only on the re-check pair. From the ports this needs the read data of the first pair to show both a toggle and the flag, followed by two equal reads. The bench's device model serves a preloaded list of read values in order, which places each of these patterns on exact read positions. The same list form drives the still-toggling failure, the poll budget limit and an abort issued between the two reads of a pair.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_CHK_A,
        ST_CHK_B,
        ST_RESET_WR,
        ST_FINISH
    } poll_state_t;

    localparam logic [15:0] RESET_CMD = 16'h00F0;
    localparam int          FLAG_IDX  = 5;

endpackage

// File: rtl/ftp_toggle_cmp.sv
module ftp_toggle_cmp #(
    parameter int DW       = 16,
    parameter int BIT_IDX  = 6,
    parameter int FLAG_IDX = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          capture,
    input  logic [DW-1:0] rdata,
    output logic          toggled,
    output logic          flag,
    output logic          held_valid
);

    logic held_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_bit   <= 1'b0;
            held_valid <= 1'b0;
        end else if (clear) begin
            held_bit   <= 1'b0;
            held_valid <= 1'b0;
        end else if (capture) begin
            held_bit   <= rdata[BIT_IDX];
            held_valid <= 1'b1;
        end
    end

    always_comb begin
        toggled = held_valid && (rdata[BIT_IDX] != held_bit);
        flag    = rdata[FLAG_IDX];
    end

    // R8: a clear always leaves no stored value behind
    a_r8_clear_drops_value: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !held_valid);

endmodule

// File: rtl/ftp_pair_counter.sv
module ftp_pair_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] pairs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pairs_q <= '0;
        end else if (clear) begin
            pairs_q <= '0;
        end else if (inc) begin
            pairs_q <= pairs_q + 1'b1;
        end
    end

    always_comb begin
        last = (limit != '0) && (pairs_q >= limit - 1'b1);
    end

    // R7: the count is never advanced on the pair that exhausts the budget
    a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last);

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
    import ftp_pkg::*;
#(
    parameter int AW         = 24,
    parameter int DW         = 16,
    parameter int CW         = 16,
    parameter bit SECTOR_BIT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] status_addr,
    input  logic [CW-1:0] poll_limit,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail
);

    localparam int TOG_IDX = SECTOR_BIT ? 2 : 6;

    poll_state_t   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          fail_q;

    logic cap, cmp_clr, cnt_clr, cnt_inc;
    logic toggled, flag, held_valid, budget_last;

    ftp_toggle_cmp #(
        .DW       (DW),
        .BIT_IDX  (TOG_IDX),
        .FLAG_IDX (FLAG_IDX)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cmp_clr),
        .capture    (cap),
        .rdata      (bus_rdata),
        .toggled    (toggled),
        .flag       (flag),
        .held_valid (held_valid)
    );

    ftp_pair_counter #(
        .CW (CW)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clr),
        .inc   (cnt_inc),
        .limit (poll_limit),
        .last  (budget_last)
    );

    // next-state and control
    always_comb begin
        state_d = state_q;
        cap     = 1'b0;
        cmp_clr = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RD_A;
                    cmp_clr = 1'b1;
                    cnt_clr = 1'b1;
                end
            end
            ST_RD_A: begin
                if (bus_ack) begin
                    cap     = 1'b1;
                    state_d = ST_RD_B;
                end
            end
            ST_RD_B: begin
                if (bus_ack) begin
                    if (!toggled) begin
                        state_d = ST_FINISH;
                    end else if (flag) begin
                        state_d = ST_CHK_A;
                    end else if (budget_last) begin
                        state_d = ST_RESET_WR;
                    end else begin
                        cnt_inc = 1'b1;
                        state_d = ST_RD_A;
                    end
                end
            end
            ST_CHK_A: begin
                if (bus_ack) begin
                    cap     = 1'b1;
                    state_d = ST_CHK_B;
                end
            end
            ST_CHK_B: begin
                if (bus_ack) begin
                    state_d = toggled ? ST_RESET_WR : ST_FINISH;
                end
            end
            ST_RESET_WR: begin
                if (bus_ack) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (abort) begin
            state_d = ST_IDLE;
            cap     = 1'b0;
            cnt_inc = 1'b0;
            cmp_clr = 1'b1;
            cnt_clr = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start && !abort) begin
                addr_q <= status_addr;
                fail_q <= 1'b0;
            end else if (state_d == ST_RESET_WR) begin
                fail_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        bus_addr  = addr_q;
        done      = 1'b0;
        fail      = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_RD_A, ST_RD_B, ST_CHK_A, ST_CHK_B: begin
                bus_req = 1'b1;
            end
            ST_RESET_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = DW'(RESET_CMD);
            end
            ST_FINISH: begin
                done = 1'b1;
                fail = fail_q;
            end
            default: begin
            end
        endcase
    end

    // R1: a pending request keeps its address and direction
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !abort |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R2: a comparison is only taken against a stored first read
    a_r2_cmp_primed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_B || state_q == ST_CHK_B) && bus_ack |-> held_valid);

    // R5: the only write carries the reset command
    a_r5_reset_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_wdata == DW'(RESET_CMD));

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: failure only qualifies a completion
    a_r6_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R8: abort leaves the machine idle with no request
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy && !bus_req && !done);

endmodule

// File: tb/flash_toggle_poller_test.sv
module flash_toggle_poller_test;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam logic [AW-1:0] SADDR = 24'h01A2B4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [AW-1:0] status_addr = SADDR;
    logic [CW-1:0] poll_limit = '0;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          busy, done, fail;

    flash_toggle_poller #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .status_addr(status_addr), .poll_limit(poll_limit),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .fail(fail)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    logic [15:0] resp [0:63];
    int ridx = 0;
    int nreads = 0, nwrites = 0;
    logic [DW-1:0] last_wdata = '0;
    logic [AW-1:0] last_waddr = '0;
    logic [AW-1:0] last_raddr = '0;
    int cyc = 0, ack_cyc = 0;
    int done_cnt = 0, done_cyc = 0;
    logic done_fail = 1'b0;
    logic prev_done = 1'b0;
    int long_done = 0;

    // device model and completion monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (done) begin
                done_cnt++;
                done_fail = fail;
                done_cyc  = cyc;
                if (prev_done) long_done++;
            end
            prev_done = done;
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                bus_ack = 1'b1;
                ack_cyc = cyc;
                if (bus_we) begin
                    nwrites++;
                    last_wdata = bus_wdata;
                    last_waddr = bus_addr;
                end else begin
                    bus_rdata  = resp[ridx];
                    last_raddr = bus_addr;
                    if (ridx < 63) ridx++;
                    nreads++;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        ridx = 0; nreads = 0; nwrites = 0; done_cnt = 0; long_done = 0;
        last_wdata = '0; last_waddr = '0;
    endtask

    task automatic fill(input logic [15:0] v);
        for (int i = 0; i < 64; i++) resp[i] = v;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (done_cnt == 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check({req, " done seen"}, done_cnt, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic run(input int limit, input string req);
        poll_limit = CW'(limit);
        clear_log();
        pulse_start();
        wait_done(req);
    endtask

    task automatic t_reset();
        check("R6 reset done", int'(done), 0);
        check("R1 reset req", int'(bus_req), 0);
        check("R8 reset busy", int'(busy), 0);
    endtask

    task automatic t_stable_first();
        fill(16'h0040);
        run(0, "R2");
        check("R2 fail flag", int'(done_fail), 0);
        check("R2 reads", nreads, 2);
        check("R2 no write", nwrites, 0);
        check("R2 done timing", done_cyc, ack_cyc + 1);
        check("R1 read addr", int'(last_raddr == SADDR), 1);
        check("R6 single cycle", long_done, 0);
    endtask

    task automatic t_toggle_then_stop();
        fill(16'h0000);
        resp[0] = 16'h0040;
        run(0, "R3");
        check("R3 reads", nreads, 4);
        check("R3 fail flag", int'(done_fail), 0);
    endtask

    task automatic t_flag_stopped();
        fill(16'h0020);
        resp[0] = 16'h0040;
        run(0, "R4");
        check("R4 reads", nreads, 4);
        check("R4 fail flag", int'(done_fail), 0);
        check("R4 no write", nwrites, 0);
    endtask

    task automatic t_flag_toggling();
        fill(16'h0060);
        resp[0] = 16'h0000; resp[1] = 16'h0060; resp[2] = 16'h0020; resp[3] = 16'h0060;
        run(0, "R5");
        check("R5 reads", nreads, 4);
        check("R5 writes", nwrites, 1);
        check("R5 wdata", int'(last_wdata), 'hF0);
        check("R5 waddr", int'(last_waddr == SADDR), 1);
        check("R5 fail flag", int'(done_fail), 1);
        check("R5 done timing", done_cyc, ack_cyc + 1);
        check("R6 single cycle fail", long_done, 0);
    endtask

    task automatic t_limit();
        for (int i = 0; i < 64; i++) resp[i] = (i % 2 == 0) ? 16'h0000 : 16'h0040;
        run(3, "R7 limit3");
        check("R7 limit3 reads", nreads, 6);
        check("R7 limit3 writes", nwrites, 1);
        check("R7 limit3 fail", int'(done_fail), 1);
        run(1, "R7 limit1");
        check("R7 limit1 reads", nreads, 2);
        check("R7 limit1 fail", int'(done_fail), 1);
        for (int i = 0; i < 64; i++) resp[i] = (i < 20) ? ((i % 2 == 0) ? 16'h0000 : 16'h0040) : 16'h0000;
        run(0, "R7 unlimited");
        check("R7 unlimited reads", nreads, 22);
        check("R7 unlimited fail", int'(done_fail), 0);
    endtask

    task automatic t_abort();
        int n = 0;
        fill(16'h0000);
        resp[0] = 16'h0040;
        clear_log();
        pulse_start();
        while (nreads < 1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R8 busy after abort", int'(busy), 0);
        check("R8 req after abort", int'(bus_req), 0);
        repeat (10) @(negedge clk);
        check("R8 no done", done_cnt, 0);
        fill(16'h0000);
        run(0, "R8 resume");
        check("R8 resume reads", nreads, 2);
        check("R8 resume fail", int'(done_fail), 0);
    endtask

    task automatic t_bit_select();
        fill(16'h0000);
        resp[0] = 16'h0004; resp[1] = 16'h0089;
        run(0, "R9");
        check("R9 reads", nreads, 2);
        check("R9 fail flag", int'(done_fail), 0);
    endtask

    task automatic t_busy_start();
        fill(16'h0000);
        resp[0] = 16'h0040;
        poll_limit = '0;
        clear_log();
        pulse_start();
        repeat (2) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10");
        repeat (6) @(negedge clk);
        check("R10 single done", done_cnt, 1);
        check("R10 reads", nreads, 4);
        check("R10 idle after", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_stable_first();
        t_toggle_then_stop();
        t_flag_stopped();
        t_flag_toggling();
        t_limit();
        t_abort();
        t_bit_select();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule